// File: doc/BRIEF.md
# Power-Aware Controller Reset Sequencer

This block derives the internal reset domains of a network controller from three sources: an active-low external reset pin, a power-up condition (the asynchronous power-on input or a fresh enabling of the controller clock), and the level of the host's run bit. It drives three synchronous reset pulses. The first is a full hardware reset for configuration and state machines. The second is a power-management clear for the power bits that the hardware reset leaves untouched. The third is a run reset for the command and interrupt state and the datapath machines.

The block also holds the 2-bit device power state, which the host writes. While that state is the deepest sleep value, a qualified external reset is dropped so that wake logic keeps running. Moving out of that state then produces one deferred hardware reset. The external pin passes through a synchronizer and a minimum-width qualifier, so short glitches never reset the controller. There is no data stream at this block's edge; every pin is a plain control or status level.

Top module: `nc_reset_seq`

## Requirements
- R1: While `por_n` is low, `hw_rst` and `pm_clr` are 1, `run_rst` is 0 and `pwr_state` is 0. After `por_n` rises, `hw_rst` and `pm_clr` stay 1 for 4 more clock cycles and then fall together.
- R2: If `ext_rst_n` is sampled low on MIN_WIDTH consecutive rising edges, `hw_rst` rises MIN_WIDTH+2 edges after the first edge that sampled it low, provided `pwr_state` is not 3 at that point.
- R3: A low on `ext_rst_n` that is sampled on fewer than MIN_WIDTH consecutive edges produces no reset.
- R4: However long `ext_rst_n` stays low, it yields exactly one hardware reset pulse.
- R5: While `pwr_state` equals 3 (deepest sleep), a qualified external reset raises no output, and `pwr_state` keeps its value.
- R6: A write that moves `pwr_state` from 3 to any other value raises `hw_rst` on the same edge that updates the state. A write of 3 while already in 3 does not do this.
- R7: `run_rst` rises on the first edge that samples `run_bit` at 0 after it was sampled at 1. A rising or steady `run_bit` produces nothing, and a run reset never raises `hw_rst`.
- R8: On the first edge that samples `clk_en` at 1 after it was sampled at 0, `hw_rst` and `pm_clr` rise together.
- R9: `pm_clr` is raised only by a power-up condition (R1, R8), never by an external reset or by leaving deepest sleep.
- R10: Each output pulse lasts exactly 4 cycles. A new trigger for an output that is already active restarts its 4-cycle count.
- R11: When `pwr_wr_en` is 1 at a rising edge, `pwr_state` takes `pwr_wr_data` on that edge. It returns to 0 only through `por_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| clk_en | input | 1 | Controller clock enable level; a 0-to-1 change is a power-up event |
| ext_rst_n | input | 1 | Asynchronous active-low external reset pin |
| run_bit | input | 1 | Host run bit level |
| pwr_wr_en | input | 1 | Power state write strobe |
| pwr_wr_data | input | 2 | Power state value to write (3 = deepest sleep) |
| pwr_state | output | 2 | Current device power state |
| hw_rst | output | 1 | Hardware reset pulse |
| pm_clr | output | 1 | Power-management clear pulse |
| run_rst | output | 1 | Run reset pulse |

## Verification
Run, clock-enable and power-state triggers land one edge after the input changes, so the pulse is seen at the next falling edge. The external pin adds two synchronizer edges to its MIN_WIDTH qualification edges, so its pulse appears MIN_WIDTH+2 edges after the pin falls. The bench's driver records each expected rise with its exact cycle number and pulse length, measured against a cycle counter, and the monitor compares every observed rise and fall against those records at falling edges. Any rise that nobody announced fails at once, which is how the dropped and ignored cases are checked. Pending expectations must be drained before each new scenario starts.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  // fixed length of every generated reset pulse, in clock cycles
  localparam int PULSE_LEN = 4;
  localparam int PCNT_W    = $clog2(PULSE_LEN + 1);

  // device power state encoding
  typedef logic [1:0] pstate_t;
  localparam pstate_t PS_ON   = 2'd0;
  localparam pstate_t PS_DEEP = 2'd3;

  // output slot order inside the pulse bank
  localparam int NUM_OUT = 3;
  localparam int IDX_HW  = 0;
  localparam int IDX_PM  = 1;
  localparam int IDX_RUN = 2;
  // slots that come out of power-on already active
  localparam logic [NUM_OUT-1:0] LOAD_ON_POR = 3'b011;
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rstseq_qual.sv
`timescale 1ns/1ps
module rstseq_qual #(
  parameter int MIN_WIDTH = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic low_i,
  output logic fire_o
);
  localparam int CW = $clog2(MIN_WIDTH + 1);
  localparam logic [CW-1:0] SAT  = CW'(MIN_WIDTH);
  localparam logic [CW-1:0] LAST = CW'(MIN_WIDTH - 1);

  logic [CW-1:0] run_len;

  // counts consecutive low samples, saturating so a long low fires once
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)             run_len <= '0;
    else if (!low_i)         run_len <= '0;
    else if (run_len != SAT) run_len <= run_len + 1'b1;
  end

  assign fire_o = low_i && (run_len == LAST);
endmodule

// File: rtl/rstseq_pulse.sv
`timescale 1ns/1ps
module rstseq_pulse
  import rstseq_pkg::*;
#(
  parameter logic LOAD_ON_RST = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam logic [PCNT_W-1:0] FULL = PCNT_W'(PULSE_LEN);

  logic [PCNT_W-1:0] left;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        left <= LOAD_ON_RST ? FULL : '0;
    else if (trig_i)    left <= FULL;
    else if (left != 0) left <= left - 1'b1;
  end

  assign pulse_o = (left != '0);
endmodule

// File: rtl/nc_reset_seq.sv
`timescale 1ns/1ps
module nc_reset_seq
  import rstseq_pkg::*;
#(
  parameter int MIN_WIDTH   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       clk_en,
  input  logic       ext_rst_n,
  input  logic       run_bit,
  input  logic       pwr_wr_en,
  input  logic [1:0] pwr_wr_data,
  output logic [1:0] pwr_state,
  output logic       hw_rst,
  output logic       pm_clr,
  output logic       run_rst
);
  logic    ext_sync_n;
  logic    ext_fire;
  logic    clk_en_q;
  logic    run_q;
  pstate_t pstate;
  logic    cen_rise;
  logic    run_fall;
  logic    leave_deep;
  logic    in_deep;
  logic [NUM_OUT-1:0] trig;
  logic [NUM_OUT-1:0] pulse;

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d_i    (ext_rst_n),
    .q_o    (ext_sync_n)
  );

  rstseq_qual #(.MIN_WIDTH(MIN_WIDTH)) u_qual (
    .clk    (clk),
    .arst_n (por_n),
    .low_i  (!ext_sync_n),
    .fire_o (ext_fire)
  );

  // edge history: clk_en history starts high so a block that comes out of
  // power-on with the clock enabled does not count a second power-up
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      clk_en_q <= 1'b1;
      run_q    <= 1'b0;
    end else begin
      clk_en_q <= clk_en;
      run_q    <= run_bit;
    end
  end

  // power state is cleared by power-on only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         pstate <= PS_ON;
    else if (pwr_wr_en) pstate <= pstate_t'(pwr_wr_data);
  end

  assign in_deep    = (pstate == PS_DEEP);
  assign cen_rise   = clk_en && !clk_en_q;
  assign run_fall   = run_q && !run_bit;
  assign leave_deep = in_deep && pwr_wr_en && (pstate_t'(pwr_wr_data) != PS_DEEP);

  always_comb begin
    trig          = '0;
    trig[IDX_HW]  = cen_rise || leave_deep || (ext_fire && !in_deep);
    trig[IDX_PM]  = cen_rise;
    trig[IDX_RUN] = run_fall;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pulse
    rstseq_pulse #(.LOAD_ON_RST(LOAD_ON_POR[g])) u_pulse (
      .clk     (clk),
      .arst_n  (por_n),
      .trig_i  (trig[g]),
      .pulse_o (pulse[g])
    );
  end

  assign hw_rst    = pulse[IDX_HW];
  assign pm_clr    = pulse[IDX_PM];
  assign run_rst   = pulse[IDX_RUN];
  assign pwr_state = pstate;
endmodule

// File: rtl/nc_reset_seq_chk.sv
`timescale 1ns/1ps
module nc_reset_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       clk_en,
  input logic       run_bit,
  input logic       pwr_wr_en,
  input logic [1:0] pwr_wr_data,
  input logic [1:0] pwr_state,
  input logic       hw_rst,
  input logic       pm_clr,
  input logic       run_rst
);
  logic past_ok;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R9: the power-management clear only ever comes with a hardware reset
  p_pm_with_hw_r9: assert property (@(posedge clk) disable iff (!por_n)
    pm_clr |-> hw_rst);

  // R8: clock enable turning on raises the power-management clear
  p_cen_rise_r8: assert property (@(posedge clk) disable iff (!por_n)
    (past_ok && $rose(clk_en)) |=> (pm_clr && hw_rst));

  // R7: a falling run bit yields a run reset
  p_run_fall_r7: assert property (@(posedge clk) disable iff (!por_n)
    (past_ok && $fell(run_bit)) |=> run_rst);

  // R10: a run reset pulse lasts at least its full length
  p_run_len_r10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_rst) |=> run_rst ##1 run_rst ##1 run_rst);

  // R6: leaving deepest sleep raises the hardware reset with the new state
  p_leave_deep_r6: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_state == 2'd3 && pwr_wr_en && pwr_wr_data != 2'd3)
      |=> (hw_rst && pwr_state == $past(pwr_wr_data)));

  // R5: without a write, deepest sleep persists
  p_hold_deep_r5: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_state == 2'd3 && !pwr_wr_en) |=> (pwr_state == 2'd3));
endmodule

bind nc_reset_seq nc_reset_seq_chk u_chk (.*);

// File: tb/nc_reset_seq_test.sv
`timescale 1ns/1ps
module nc_reset_seq_test;
  localparam int MINW = 8;
  localparam int K_HW = 0, K_PM = 1, K_RUN = 2;

  typedef struct {
    int    kind;
    int    cyc;
    int    len;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       por_n, clk_en, ext_rst_n, run_bit, pwr_wr_en;
  logic [1:0] pwr_wr_data, pwr_state;
  logic       hw_rst, pm_clr, run_rst;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nc_reset_seq #(.MIN_WIDTH(MINW)) uut (
    .clk(clk), .por_n(por_n), .clk_en(clk_en), .ext_rst_n(ext_rst_n),
    .run_bit(run_bit), .pwr_wr_en(pwr_wr_en), .pwr_wr_data(pwr_wr_data),
    .pwr_state(pwr_state), .hw_rst(hw_rst), .pm_clr(pm_clr), .run_rst(run_rst)
  );

  function automatic string kname(int k);
    return (k == K_HW) ? "hw_rst" : (k == K_PM) ? "pm_clr" : "run_rst";
  endfunction

  function automatic string kreq(int k);
    return (k == K_HW) ? "R3" : (k == K_PM) ? "R9" : "R7";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int kind, int c, int len, string req);
    exp_t e;
    e.kind = kind; e.cyc = c; e.len = len; e.req = req;
    q.push_back(e);
  endtask

  // monitor: every rise must be announced, every pulse must have its length
  int    start_c [3];
  int    want_len[3];
  string cur_req [3];
  bit    prv     [3];
  always @(negedge clk) begin
    if (mon_on) begin
      for (int k = 0; k < 3; k++) begin
        bit cur;
        cur = (k == K_HW) ? hw_rst : (k == K_PM) ? pm_clr : run_rst;
        if (cur && !prv[k]) begin
          checks++;
          if (q.size() == 0 || q[0].kind != k || q[0].cyc != cyc) begin
            fails++;
            if (q.size() == 0)
              $display("FAIL %s unannounced rise of %s: actual cycle %0d expected none",
                       kreq(k), kname(k), cyc);
            else
              $display("FAIL %s rise of %s: actual cycle %0d expected %s at cycle %0d",
                       q[0].req, kname(k), cyc, kname(q[0].kind), q[0].cyc);
            want_len[k] = 4;
            cur_req[k]  = kreq(k);
          end else begin
            want_len[k] = q[0].len;
            cur_req[k]  = q[0].req;
            void'(q.pop_front());
          end
          start_c[k] = cyc;
        end
        if (!cur && prv[k])
          check((cyc - start_c[k]) == want_len[k], cur_req[k],
                {kname(k), " pulse length"}, cyc - start_c[k], want_len[k]);
        prv[k] = cur;
      end
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s %s never rose: actual not seen expected cycle %0d",
               q[0].req, kname(q[0].kind), q[0].cyc);
      q.delete();
    end
  endtask

  task automatic ext_low(int width, bit expect_hw, string req);
    @(negedge clk);
    if (expect_hw) push(K_HW, cyc + MINW + 2, 4, req);
    ext_rst_n = 1'b0;
    repeat (width) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  task automatic set_run(logic v, bit expect_run);
    @(negedge clk);
    if (expect_run) push(K_RUN, cyc + 1, 4, "R7");
    run_bit = v;
  endtask

  task automatic wr_pwr(logic [1:0] v, bit expect_hw, string req);
    @(negedge clk);
    if (expect_hw) push(K_HW, cyc + 1, 4, req);
    pwr_wr_en = 1'b1;
    pwr_wr_data = v;
    @(negedge clk);
    pwr_wr_en = 1'b0;
    check(pwr_state == v, "R11", "pwr_state after write", pwr_state, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; clk_en = 1'b1; ext_rst_n = 1'b1; run_bit = 1'b0;
    pwr_wr_en = 1'b0; pwr_wr_data = 2'd0;
    repeat (3) @(negedge clk);
    // R1: state while power-on is held
    check(hw_rst == 1'b1, "R1", "hw_rst in power-on", hw_rst, 1);
    check(pm_clr == 1'b1, "R1", "pm_clr in power-on", pm_clr, 1);
    check(run_rst == 1'b0, "R1", "run_rst in power-on", run_rst, 0);
    check(pwr_state == 2'd0, "R1", "pwr_state in power-on", pwr_state, 0);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    check(hw_rst && pm_clr, "R1", "pulse 3 cycles after release", hw_rst & pm_clr, 1);
    @(negedge clk);
    check(!hw_rst && !pm_clr, "R1", "pulse 4 cycles after release", hw_rst | pm_clr, 0);
    mon_on = 1'b1;

    // R2: exactly minimum width qualifies (R9: no pm_clr follows)
    ext_low(MINW, 1'b1, "R2");
    settle(20);
    // R3: one sample short is ignored
    ext_low(MINW - 1, 1'b0, "R3");
    settle(20);
    // R4: long low gives one pulse only
    ext_low(40, 1'b1, "R4");
    settle(12);

    // R7: rising and steady run bit do nothing; falling gives run reset only
    set_run(1'b1, 1'b0);
    settle(6);
    set_run(1'b0, 1'b1);
    settle(8);
    set_run(1'b0, 1'b0);
    settle(6);

    // R11: ordinary writes load the state without resets
    wr_pwr(2'd1, 1'b0, "R11");
    wr_pwr(2'd2, 1'b0, "R11");
    settle(4);

    // R5: external reset in deepest sleep is dropped, state kept
    wr_pwr(2'd3, 1'b0, "R5");
    ext_low(30, 1'b0, "R5");
    settle(10);
    check(pwr_state == 2'd3, "R5", "pwr_state after blocked reset", pwr_state, 3);
    // R6: rewriting 3 while in 3 is no exit
    wr_pwr(2'd3, 1'b0, "R6");
    settle(6);
    // R6: leaving deepest sleep gives one deferred reset (R9: no pm_clr)
    wr_pwr(2'd0, 1'b1, "R6");
    settle(8);

    // R6: exit while the pin is still held low gives exactly one pulse
    wr_pwr(2'd3, 1'b0, "R6");
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (15) @(negedge clk);
    wr_pwr(2'd2, 1'b1, "R6");
    repeat (30) @(negedge clk);
    ext_rst_n = 1'b1;
    settle(12);

    // R8: clock enable off is quiet, on raises both outputs
    @(negedge clk);
    clk_en = 1'b0;
    settle(4);
    @(negedge clk);
    push(K_HW, cyc + 1, 4, "R8");
    push(K_PM, cyc + 1, 4, "R8");
    clk_en = 1'b1;
    settle(8);

    // R10: exit two cycles after a power-up restarts the hardware count
    wr_pwr(2'd3, 1'b0, "R10");
    @(negedge clk);
    clk_en = 1'b0;
    @(negedge clk);
    push(K_HW, cyc + 1, 6, "R10");
    push(K_PM, cyc + 1, 4, "R10");
    clk_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    pwr_wr_en = 1'b1;
    pwr_wr_data = 2'd0;
    @(negedge clk);
    pwr_wr_en = 1'b0;
    settle(10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule